// File: doc/BRIEF.md
# Waveform Amplitude RAM Serial Port

This block is a slave serial port. An external host uses it to reach a small register file and an amplitude memory with one entry per pulse phase. The host frames each access with an active-low chip select. It shifts bits in on serial data in, and each bit is captured on a rising serial clock edge. Read data comes back on serial data out, which changes only after a falling serial clock edge. Every byte travels least significant bit first.

A plain access has two bytes: a command byte, then one data byte. When the command names the indirect RAM register at address 0x13, the port switches to a three-byte access. The byte after the command is a memory location in the range 0x00 to 0x29. The third byte is then either written to that location or driven out from it. The amplitude for the first phase of a symbol belongs at location 0x00, and later phases follow at rising locations. A full-scale amplitude has the code 0x3F.

The serial pins are synchronised into the system clock domain and their edges are detected there. The serial clock must therefore run several times slower than the system clock.

Top module: `wave_ram_port`

## Requirements
- R1: After reset every register and every RAM location reads 0x00, and sdo_o is low.
- R2: A command byte carries read/write in bit 0 (1 = read, 0 = write) and the register address in bits 7:1. All bytes shift least significant bit first.
- R3: A write command to a register address below REG_CNT, followed by a data byte, stores that byte in the register.
- R4: A read command places the addressed value on sdo_o, least significant bit first, during the byte that follows the command.
- R5: Writes to a register address at or above REG_CNT, other than 0x13, change nothing. Reads from such an address return 0x00.
- R6: A write command naming 0x13 makes a three-byte access. The second byte selects the RAM location and the third byte is stored there.
- R7: A read command naming 0x13 drives the selected RAM location out on sdo_o during the third byte.
- R8: A RAM location above 0x29 is ignored on writes and reads back as 0x00.
- R9: Raising cs_ni during a sequence abandons it without writing. The port then forces sdo_o low and treats the next byte after cs_ni falls as a new command.
- R10: Bytes that follow a completed sequence within the same chip select window change no stored value.
- R11: sdi_i is taken on the sclk_i rising edge. sdo_o changes only after an sclk_i falling edge or after cs_ni is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| sdi_i | input | 1 | Serial data in, least significant bit first |
| sdo_o | output | 1 | Serial data out, least significant bit first |

## Verification
A bad sequencer state shows up at the next read-back. A port that takes the RAM register for a plain register, or loses its place after an abort, either returns a wrong byte on sdo_o or corrupts a location that a later read reveals. That failure appears within the next transaction that touches the location. A bad output shifter shows up inside the read byte itself: bits come out in the wrong order, or sdo_o changes while sclk_i is high. An out-of-range write that lands in memory only shows when the aliased location is read, so the random mix keeps reading back locations near the top of the RAM and the register file.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  localparam int DW        = 8;
  localparam int AW        = 7;
  localparam logic [AW-1:0] RAM_SEL = 7'h13;

  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_RADDR = 2'd1,
    ST_DATA  = 2'd2,
    ST_DONE  = 2'd3
  } st_e;
endpackage

// File: rtl/wrp_sync.sv
module wrp_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [2:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {3{RST_VAL[g]}};
      else         pipe_q <= {pipe_q[1:0], d_i[g]};
    end
    assign q_o[g]    = pipe_q[1];
    assign prev_o[g] = pipe_q[2];
  end
endmodule

// File: rtl/wrp_mem.sv
module wrp_mem #(
  parameter int DW        = 8,
  parameter int REG_CNT   = 16,
  parameter int RAM_DEPTH = 42
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [6:0]    reg_waddr_i,
  input  logic [6:0]    reg_raddr_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          ram_we_i,
  input  logic [7:0]    ram_waddr_i,
  input  logic [7:0]    ram_raddr_i,
  output logic [DW-1:0] ram_rdata_o,
  input  logic [DW-1:0] wdata_i
);
  localparam int RIW = $clog2(REG_CNT);
  localparam int MIW = $clog2(RAM_DEPTH);

  logic [DW-1:0] reg_q [REG_CNT];
  logic [DW-1:0] ram_q [RAM_DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REG_CNT; i++) reg_q[i] <= '0;
    end else if (reg_we_i && 32'(reg_waddr_i) < REG_CNT) begin
      reg_q[reg_waddr_i[RIW-1:0]] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
    end else if (ram_we_i && 32'(ram_waddr_i) < RAM_DEPTH) begin
      ram_q[ram_waddr_i[MIW-1:0]] <= wdata_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    ram_rdata_o = '0;
    if (32'(reg_raddr_i) < REG_CNT) reg_rdata_o = reg_q[reg_raddr_i[RIW-1:0]];
    if (32'(ram_raddr_i) < RAM_DEPTH) ram_rdata_o = ram_q[ram_raddr_i[MIW-1:0]];
  end
endmodule

// File: rtl/wrp_seq.sv
module wrp_seq
  import wrp_pkg::*;
#(
  parameter int REG_CNT   = 16,
  parameter int RAM_DEPTH = 42
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_idle_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          sdi_i,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_waddr_o,
  output logic [AW-1:0] reg_raddr_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          ram_we_o,
  output logic [7:0]    ram_waddr_o,
  output logic [7:0]    ram_raddr_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic [DW-1:0] wdata_o,
  output st_e           state_o,
  output logic          sdo_o
);
  st_e           st_q;
  logic [2:0]    bit_q;
  logic [DW-1:0] sh_q, sh_n, out_q;
  logic          rd_q, ram_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    loc_q;
  logic          byte_end;

  assign sh_n     = {sdi_i, sh_q[DW-1:1]};
  assign byte_end = rise_i && (bit_q == 3'd7);

  // lookahead read addresses: data must be ready when the byte closes
  assign reg_raddr_o = sh_n[DW-1:1];
  assign ram_raddr_o = sh_n;

  assign reg_we_o    = byte_end && st_q == ST_DATA && !rd_q && !ram_q &&
                       32'(addr_q) < REG_CNT;
  assign ram_we_o    = byte_end && st_q == ST_DATA && !rd_q && ram_q &&
                       32'(loc_q) < RAM_DEPTH;
  assign reg_waddr_o = addr_q;
  assign ram_waddr_o = loc_q;
  assign wdata_o     = sh_n;
  assign state_o     = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CMD;
      bit_q  <= '0;
      sh_q   <= '0;
      out_q  <= '0;
      rd_q   <= 1'b0;
      ram_q  <= 1'b0;
      addr_q <= '0;
      loc_q  <= '0;
      sdo_o  <= 1'b0;
    end else if (cs_idle_i) begin
      st_q  <= ST_CMD;
      bit_q <= '0;
      out_q <= '0;
      ram_q <= 1'b0;
      sdo_o <= 1'b0;
    end else if (rise_i) begin
      sh_q  <= sh_n;
      bit_q <= bit_q + 3'd1;
      if (byte_end) begin
        unique case (st_q)
          ST_CMD: begin
            rd_q   <= sh_n[0];
            addr_q <= sh_n[DW-1:1];
            if (sh_n[DW-1:1] == RAM_SEL) begin
              ram_q <= 1'b1;
              st_q  <= ST_RADDR;
            end else begin
              st_q <= ST_DATA;
              if (sh_n[0]) out_q <= (sh_n[DW-1:1] == RAM_SEL) ? '0 : reg_rdata_i;
            end
          end
          ST_RADDR: begin
            loc_q <= sh_n;
            st_q  <= ST_DATA;
            if (rd_q) out_q <= ram_rdata_i;
          end
          ST_DATA: st_q <= ST_DONE;
          ST_DONE: st_q <= ST_DONE;
        endcase
      end
    end else if (fall_i && (st_q == ST_DATA || st_q == ST_DONE)) begin
      sdo_o <= out_q[0];
      out_q <= {1'b0, out_q[DW-1:1]};
    end
  end
endmodule

// File: rtl/wave_ram_port.sv
module wave_ram_port
  import wrp_pkg::*;
#(
  parameter int REG_CNT   = 16,
  parameter int RAM_DEPTH = 42
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o
);
  logic [2:0] pin_s, pin_p;
  logic cs_idle, sclk_rise, sclk_fall;
  logic reg_we, ram_we;
  logic [AW-1:0] reg_waddr, reg_raddr;
  logic [7:0] ram_waddr, ram_raddr;
  logic [DW-1:0] reg_rdata, ram_rdata, wdata;
  st_e state;

  wrp_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (pin_s), .prev_o(pin_p)
  );

  assign cs_idle   = pin_s[2];
  assign sclk_rise = pin_s[1] & ~pin_p[1];
  assign sclk_fall = ~pin_s[1] & pin_p[1];

  wrp_seq #(.REG_CNT(REG_CNT), .RAM_DEPTH(RAM_DEPTH)) u_seq (
    .clk_i      (clk_i),     .rst_ni     (rst_ni),
    .cs_idle_i  (cs_idle),   .rise_i     (sclk_rise),
    .fall_i     (sclk_fall), .sdi_i      (pin_s[0]),
    .reg_we_o   (reg_we),    .reg_waddr_o(reg_waddr),
    .reg_raddr_o(reg_raddr), .reg_rdata_i(reg_rdata),
    .ram_we_o   (ram_we),    .ram_waddr_o(ram_waddr),
    .ram_raddr_o(ram_raddr), .ram_rdata_i(ram_rdata),
    .wdata_o    (wdata),     .state_o    (state),
    .sdo_o      (sdo_o)
  );

  wrp_mem #(.DW(DW), .REG_CNT(REG_CNT), .RAM_DEPTH(RAM_DEPTH)) u_mem (
    .clk_i      (clk_i),     .rst_ni     (rst_ni),
    .reg_we_i   (reg_we),    .reg_waddr_i(reg_waddr),
    .reg_raddr_i(reg_raddr), .reg_rdata_o(reg_rdata),
    .ram_we_i   (ram_we),    .ram_waddr_i(ram_waddr),
    .ram_raddr_i(ram_raddr), .ram_rdata_o(ram_rdata),
    .wdata_i    (wdata)
  );
endmodule

// File: rtl/wrp_chk.sv
module wrp_chk
  import wrp_pkg::*;
#(
  parameter int REG_CNT   = 16,
  parameter int RAM_DEPTH = 42
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_idle,
  input logic       sclk_fall,
  input logic       sdo_o,
  input logic       reg_we,
  input logic       ram_we,
  input logic [6:0] reg_waddr,
  input logic [7:0] ram_waddr,
  input st_e        state
);
  // R9
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_idle |=> (state == ST_CMD && !sdo_o));
  // R5
  reg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |-> 32'(reg_waddr) < REG_CNT);
  // R8
  ram_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> 32'(ram_waddr) < RAM_DEPTH);
  // R11
  sdo_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $past(sclk_fall || cs_idle));
  // R6
  we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we && ram_we));
  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_DONE |-> (!reg_we && !ram_we));
endmodule

bind wave_ram_port wrp_chk #(.REG_CNT(REG_CNT), .RAM_DEPTH(RAM_DEPTH)) u_chk (
  .clk_i    (clk_i),     .rst_ni   (rst_ni),
  .cs_idle  (cs_idle),   .sclk_fall(sclk_fall),
  .sdo_o    (sdo_o),     .reg_we   (reg_we),
  .ram_we   (ram_we),    .reg_waddr(reg_waddr),
  .ram_waddr(ram_waddr), .state    (state)
);

// File: tb/tb_wave_ram_port.sv
module tb_wave_ram_port;
  localparam int HALF = 6;
  localparam int NREG = 16;
  localparam int NRAM = 42;

  logic clk = 0, rst_ni = 0, cs_ni = 1, sclk_i = 0, sdi_i = 0;
  logic sdo_o;
  int   n_chk = 0, n_err = 0, glitch = 0;
  logic [7:0] m_reg [NREG];
  logic [7:0] m_ram [NRAM];
  logic [7:0] rx;

  always #5 clk = ~clk;

  wave_ram_port dut (.clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni),
                     .sclk_i(sclk_i), .sdi_i(sdi_i), .sdo_o(sdo_o));

  function automatic logic [7:0] exp_reg(input logic [6:0] a);
    return (a < NREG) ? m_reg[a] : 8'h00;
  endfunction
  function automatic logic [7:0] exp_ram(input logic [7:0] l);
    return (l < NRAM) ? m_ram[l] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one byte, LSB first; rx sampled just before each rising edge
  task automatic xfer(input logic [7:0] tx, output logic [7:0] r);
    logic hold;
    for (int i = 0; i < 8; i++) begin
      sdi_i = tx[i];
      wait_clk(HALF);
      r[i] = sdo_o;
      sclk_i = 1;
      wait_clk(HALF/2);
      hold = sdo_o;
      wait_clk(HALF - HALF/2);
      if (hold !== r[i]) glitch++;
      sclk_i = 0;
    end
  endtask

  task automatic sel(); cs_ni = 0; wait_clk(HALF); endtask
  task automatic desel(); wait_clk(HALF); cs_ni = 1; wait_clk(2*HALF); endtask

  task automatic reg_wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    sel(); xfer({a, 1'b0}, r); xfer(d, r); desel();
    if (a < NREG) m_reg[a] = d;
  endtask
  task automatic reg_rd(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] r;
    sel(); xfer({a, 1'b1}, r); xfer(8'h00, d); desel();
  endtask
  task automatic ram_wr(input logic [7:0] l, input logic [7:0] d);
    logic [7:0] r;
    sel(); xfer({7'h13, 1'b0}, r); xfer(l, r); xfer(d, r); desel();
    if (l < NRAM) m_ram[l] = d;
  endtask
  task automatic ram_rd(input logic [7:0] l, output logic [7:0] d);
    logic [7:0] r;
    sel(); xfer({7'h13, 1'b1}, r); xfer(l, r); xfer(8'h00, d); desel();
  endtask

  initial begin
    int seed;
    logic [7:0] r;
    seed = $urandom(32'h5eed);
    for (int i = 0; i < NREG; i++) m_reg[i] = 8'h00;
    for (int i = 0; i < NRAM; i++) m_ram[i] = 8'h00;
    wait_clk(4);
    rst_ni = 1;
    wait_clk(4);

    // R1 reset state
    chk("R1 sdo idle", {7'd0, sdo_o}, 8'h00);
    reg_rd(7'd5, r);    chk("R1 reg after reset", r, 8'h00);
    ram_rd(8'd41, r);   chk("R1 ram after reset", r, 8'h00);

    // R2 R3 R4 command format, register write and read
    reg_wr(7'd3, 8'hA5); reg_rd(7'd3, r); chk("R2 R3 R4 reg rdback", r, 8'hA5);
    reg_wr(7'd15, 8'h81); reg_rd(7'd15, r); chk("R4 lsb-first top reg", r, 8'h81);

    // R5 out-of-range register
    reg_wr(7'd40, 8'h77); reg_rd(7'd40, r); chk("R5 unmapped read", r, 8'h00);
    reg_rd(7'd8, r); chk("R5 no alias into reg 8", r, exp_reg(7'd8));

    // R6 R7 RAM: first phase at 0, full scale at last
    ram_wr(8'd0, 8'h3F); ram_wr(8'd41, 8'h3F); ram_wr(8'd1, 8'h12);
    ram_rd(8'd0, r);  chk("R6 R7 ram loc0", r, 8'h3F);
    ram_rd(8'd41, r); chk("R7 ram loc41", r, 8'h3F);
    ram_rd(8'd1, r);  chk("R7 ram loc1", r, 8'h12);

    // R8 beyond 0x29
    ram_wr(8'd42, 8'h55); ram_wr(8'hFF, 8'h66);
    ram_rd(8'd42, r); chk("R8 read loc 0x2a", r, 8'h00);
    ram_rd(8'd0, r);  chk("R8 no alias loc0", r, 8'h3F);
    ram_rd(8'd10, r); chk("R8 no alias loc10", r, 8'h00);

    // R9 abort after RAM location byte
    sel(); xfer({7'h13, 1'b0}, r); xfer(8'd1, r); sdi_i = 1; wait_clk(HALF);
    sclk_i = 1; wait_clk(HALF); sclk_i = 0; desel();
    chk("R9 sdo low after abort", {7'd0, sdo_o}, 8'h00);
    ram_rd(8'd1, r); chk("R9 aborted write dropped", r, 8'h12);
    // R9 abort after command; next byte must be a command
    sel(); xfer({7'd4, 1'b0}, r); desel();
    reg_rd(7'd4, r); chk("R9 abort after cmd", r, 8'h00);

    // R10 trailing bytes ignored
    sel(); xfer({7'd6, 1'b0}, r); xfer(8'h5A, r); xfer({7'd7, 1'b0}, r); xfer(8'hC3, r); desel();
    m_reg[6] = 8'h5A;
    reg_rd(7'd6, r); chk("R10 first write kept", r, 8'h5A);
    reg_rd(7'd7, r); chk("R10 trailing ignored", r, 8'h00);

    // random mix
    for (int k = 0; k < 150; k++) begin
      int op;
      logic [6:0] a;
      logic [7:0] l, d;
      op = int'($urandom % 4);
      a  = 7'($urandom % 32);
      if (a == 7'h13) a = 7'h12;
      l  = 8'($urandom % 64);
      d  = ($urandom % 5 == 0) ? 8'h3F : 8'($urandom);
      case (op)
        0: reg_wr(a, d);
        1: begin reg_rd(a, r); chk("R4 R5 random reg", r, exp_reg(a)); end
        2: ram_wr(l, d);
        default: begin ram_rd(l, r); chk("R7 R8 random ram", r, exp_ram(l)); end
      endcase
    end

    // R11 sdo held across each high phase of sclk
    chk("R11 sdo stable while sclk high", 8'(glitch), 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_err);
    $finish;
  end
endmodule